// File: doc/BRIEF.md
# Programmable-Polynomial CRC Word Engine

This block computes a CRC over a stream of data words using a polynomial that software chooses at run time. Writing the polynomial register starts an internal build of a 256-entry lookup table, one entry per clock. A table-ready status bit reports when the build has finished. After that, software seeds the running CRC, loads the number of words to process, and sets the run bit together with an operating mode. Words then flow in through a valid/ready input.

The engine consumes each word one byte per clock through the table, starting with the most significant byte. It uses a non-reflected shift-left CRC and applies no final inversion. When the last counted word has been folded in, the core copies the running CRC into a separate read-only result register. It also sets a sticky expiry flag. In compare mode it additionally raises a mismatch flag if that result differs from a programmed expected value. Each flag can drive the interrupt line through its own enable bit.

Top module: `crc_accel`

## Requirements
- R1: After reset the control register, status register and result register read 0, and both `irq` and `in_ready` are low.
- R2: A write to the polynomial register (address 4) clears the table-ready status bit (STATUS bit 2) and restarts the table build. The bit reads 1 exactly 256 clock edges after the write edge, and no earlier.
- R3: `in_ready` is high only while all of these hold: the run bit (CTRL bit 0) is set, the mode (CTRL bits 2:1) is 01 (calculate) or 10 (compare), the table is ready, the word count is nonzero, and the engine is idle. While it is low, an offered word leaves the count unchanged.
- R4: The result equals a shift-left CRC of the accepted words, seeded from the value written to the current-CRC register (address 5). Each word is fed most significant bit first, with no reflection and no final XOR. The result is read at address 6.
- R5: The word count (address 7) decrements by one per accepted word and never wraps below zero.
- R6: When the last counted word has been processed, STATUS bit 0 (count expired) is set and the result register is updated.
- R7: STATUS bits 0 and 1 are sticky. Writing 1 to a bit clears it; writing 0 leaves it unchanged.
- R8: `irq` is the registered OR of (STATUS bit 0 AND enable bit 0) and (STATUS bit 1 AND enable bit 1). Enables are set by writing ones to address 2 and cleared by writing ones to address 3. Address 2 reads back the enable bits.
- R9: In compare mode (CTRL bits 2:1 = 10), STATUS bit 1 is set at expiry if the result differs from the compare register (address 9). It is left clear if they match. Calculate mode never sets it.
- R10: Writing 0 to the control register clears both the run bit and the mode, and word acceptance stops.
- R11: The current-CRC register reads back the last seed written while no word is in flight.
- R12: The count-reload register (address 8) stores and reads back any 32-bit value, including 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears after the next edge |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| in_valid | input | 1 | Input word offered |
| in_data | input | DATA_W | Input word |
| in_ready | output | 1 | Engine takes the word at this edge |
| irq | output | 1 | Registered interrupt request |

## Verification
Some properties are checked on every cycle. The count must step down exactly once per accepted word and must stay at zero on its own. The table-ready bit may rise only on the edge that writes the final table entry. The expiry flag must be sticky until a write-one clear. The interrupt must follow only enabled flags. The mismatch flag may rise only in compare mode. A zeroed control write must stop the run.

Other behaviour is shown only by the bench's scenarios. These include the numeric CRC value for two polynomials and several seeds, the exact 256-cycle build latency after a restarted build, the count read back in the middle of a job, and interrupt gating toggled while a flag is already pending.

// File: rtl/crc_accel_pkg.sv
package crc_accel_pkg;

  // register word addresses
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_STATUS  = 1;
  localparam int unsigned A_IE_SET  = 2;
  localparam int unsigned A_IE_CLR  = 3;
  localparam int unsigned A_POLY    = 4;
  localparam int unsigned A_SEED    = 5;
  localparam int unsigned A_RESULT  = 6;
  localparam int unsigned A_COUNT   = 7;
  localparam int unsigned A_RELOAD  = 8;
  localparam int unsigned A_COMPARE = 9;

  // status / enable bit positions
  localparam int unsigned ST_EXPIRED = 0;
  localparam int unsigned ST_MISMATCH = 1;
  localparam int unsigned ST_TBL_READY = 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_CALC = 2'b01,
    MODE_CMP  = 2'b10,
    MODE_RSV  = 2'b11
  } crc_mode_e;

endpackage

// File: rtl/crc_tbl_ram.sv
module crc_tbl_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps to a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/crc_lut_build.sv
module crc_lut_build #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poly_we,
  input  logic [DATA_W-1:0] poly,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  localparam int DEPTH = 1 << BYTE_W;
  localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(DEPTH - 1);

  logic              building;
  logic [BYTE_W-1:0] idx;

  // one table entry: the index pushed through BYTE_W shift steps
  function automatic logic [DATA_W-1:0] entry_of(input logic [BYTE_W-1:0] i,
                                                 input logic [DATA_W-1:0] p);
    logic [DATA_W-1:0] r;
    r = {i, {(DATA_W-BYTE_W){1'b0}}};
    for (int b = 0; b < BYTE_W; b++) begin
      r = r[DATA_W-1] ? ((r << 1) ^ p) : (r << 1);
    end
    return r;
  endfunction

  assign wr_en   = building;
  assign wr_addr = idx;
  assign wr_data = entry_of(idx, poly);

  always_ff @(posedge clk) begin
    if (rst) begin
      building <= 1'b0;
      idx      <= '0;
      done     <= 1'b0;
    end else if (poly_we) begin
      building <= 1'b1;
      idx      <= '0;
      done     <= 1'b0;
    end else if (building) begin
      idx <= idx + 1'b1;
      if (idx == LAST_IDX) begin
        building <= 1'b0;
        done     <= 1'b1;
      end
    end
  end

  // R2: ready rises only on the edge that writes the final entry
  p_done_on_last_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(building) && $past(idx) == LAST_IDX));

  // R2: a polynomial write always drops the ready flag
  p_restart_clears_r2: assert property (@(posedge clk) disable iff (rst)
    poly_we |=> !done);
endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_we,
  input  logic [DATA_W-1:0] seed_val,
  input  logic              start,
  input  logic [DATA_W-1:0] word,
  input  logic              last_word,
  input  logic [DATA_W-1:0] tbl_q,
  output logic [BYTE_W-1:0] tbl_raddr,
  output logic [DATA_W-1:0] crc,
  output logic              busy,
  output logic              fin
);
  localparam int NB    = DATA_W / BYTE_W;
  localparam int IDX_W = $clog2(NB + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NB);

  logic [DATA_W-1:0] wbuf;
  logic [DATA_W-1:0] crc_step;
  logic [IDX_W-1:0]  bidx;
  logic              last_q;

  function automatic logic [BYTE_W-1:0] byte_of(input logic [DATA_W-1:0] w,
                                                input int k);
    if (k < NB) return w[DATA_W-1-k*BYTE_W -: BYTE_W];
    return '0;
  endfunction

  // fold the byte looked up in the previous cycle
  assign crc_step = {crc[DATA_W-BYTE_W-1:0], {BYTE_W{1'b0}}} ^ tbl_q;

  always_comb begin
    if (busy)
      tbl_raddr = crc_step[DATA_W-1 -: BYTE_W] ^ byte_of(wbuf, int'(bidx));
    else
      tbl_raddr = crc[DATA_W-1 -: BYTE_W] ^ word[DATA_W-1 -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc    <= '0;
      wbuf   <= '0;
      bidx   <= '0;
      busy   <= 1'b0;
      last_q <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (busy) begin
        crc <= crc_step;
        if (bidx == IDX_END) begin
          busy <= 1'b0;
          fin  <= last_q;
        end else begin
          bidx <= bidx + 1'b1;
        end
      end else if (start) begin
        busy   <= 1'b1;
        bidx   <= IDX_W'(1);
        wbuf   <= word;
        last_q <= last_word;
      end
      if (seed_we) crc <= seed_val;
    end
  end

  // R4: each word occupies exactly NB busy cycles
  p_word_begin_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> bidx == IDX_W'(1));
  p_word_end_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && bidx == IDX_END) |=> !busy);
  p_fin_after_word_r6: assert property (@(posedge clk) disable iff (rst)
    fin |-> !busy && $past(busy));
endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_accel_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              irq
);
  // address decode
  logic w_ctrl, w_status, w_ie_set, w_ie_clr, w_poly, w_seed, w_count, w_reload, w_cmp;
  assign w_ctrl   = bus_wr && bus_addr == ADDR_W'(A_CTRL);
  assign w_status = bus_wr && bus_addr == ADDR_W'(A_STATUS);
  assign w_ie_set = bus_wr && bus_addr == ADDR_W'(A_IE_SET);
  assign w_ie_clr = bus_wr && bus_addr == ADDR_W'(A_IE_CLR);
  assign w_poly   = bus_wr && bus_addr == ADDR_W'(A_POLY);
  assign w_seed   = bus_wr && bus_addr == ADDR_W'(A_SEED);
  assign w_count  = bus_wr && bus_addr == ADDR_W'(A_COUNT);
  assign w_reload = bus_wr && bus_addr == ADDR_W'(A_RELOAD);
  assign w_cmp    = bus_wr && bus_addr == ADDR_W'(A_COMPARE);

  // register state
  logic              run_en;
  crc_mode_e         mode;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] reload_r, poly_r, compare_r, result_r;
  logic              st_exp, st_mis;
  logic [1:0]        ie;

  // sub-block wiring
  logic              tbl_we, tbl_ready;
  logic [BYTE_W-1:0] tbl_waddr, tbl_raddr;
  logic [DATA_W-1:0] tbl_wdata, tbl_q;
  logic [DATA_W-1:0] crc_now;
  logic              eng_busy, eng_fin;
  logic              mode_ok, accept;
  logic [1:0]        flags;

  assign mode_ok  = (mode == MODE_CALC) || (mode == MODE_CMP);
  assign in_ready = run_en && mode_ok && tbl_ready && (count != '0) && !eng_busy;
  assign accept   = in_valid && in_ready;
  assign flags    = {st_mis, st_exp};

  crc_lut_build #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_build (
    .clk     (clk),
    .rst     (rst),
    .poly_we (w_poly),
    .poly    (poly_r),
    .wr_en   (tbl_we),
    .wr_addr (tbl_waddr),
    .wr_data (tbl_wdata),
    .done    (tbl_ready)
  );

  crc_tbl_ram #(.AW(BYTE_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (tbl_raddr),
    .rdata (tbl_q)
  );

  crc_word_engine #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .seed_we   (w_seed),
    .seed_val  (bus_wdata),
    .start     (accept),
    .word      (in_data),
    .last_word (count == CNT_W'(1)),
    .tbl_q     (tbl_q),
    .tbl_raddr (tbl_raddr),
    .crc       (crc_now),
    .busy      (eng_busy),
    .fin       (eng_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      mode      <= MODE_OFF;
      count     <= '0;
      reload_r  <= '0;
      poly_r    <= '0;
      compare_r <= '0;
      result_r  <= '0;
      st_exp    <= 1'b0;
      st_mis    <= 1'b0;
      ie        <= '0;
      irq       <= 1'b0;
    end else begin
      if (w_ctrl) begin
        run_en <= bus_wdata[0];
        mode   <= crc_mode_e'(bus_wdata[2:1]);
      end
      if (w_count)      count <= bus_wdata[CNT_W-1:0];
      else if (accept)  count <= count - CNT_W'(1);
      if (w_reload) reload_r  <= bus_wdata;
      if (w_poly)   poly_r    <= bus_wdata;
      if (w_cmp)    compare_r <= bus_wdata;

      if (w_ie_set)      ie <= ie | bus_wdata[1:0];
      else if (w_ie_clr) ie <= ie & ~bus_wdata[1:0];

      // sticky flags: a completing job wins over a same-cycle clear
      st_exp <= (st_exp && !(w_status && bus_wdata[ST_EXPIRED])) || eng_fin;
      st_mis <= (st_mis && !(w_status && bus_wdata[ST_MISMATCH])) ||
                (eng_fin && mode == MODE_CMP && crc_now != compare_r);
      if (eng_fin) result_r <= crc_now;

      irq <= |(flags & ie);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(A_CTRL):    bus_rdata <= DATA_W'({mode, run_en});
        ADDR_W'(A_STATUS):  bus_rdata <= DATA_W'({tbl_ready, st_mis, st_exp});
        ADDR_W'(A_IE_SET):  bus_rdata <= DATA_W'(ie);
        ADDR_W'(A_POLY):    bus_rdata <= poly_r;
        ADDR_W'(A_SEED):    bus_rdata <= crc_now;
        ADDR_W'(A_RESULT):  bus_rdata <= result_r;
        ADDR_W'(A_COUNT):   bus_rdata <= DATA_W'(count);
        ADDR_W'(A_RELOAD):  bus_rdata <= reload_r;
        ADDR_W'(A_COMPARE): bus_rdata <= compare_r;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  // R5: one step down per accepted word
  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && !w_count) |=> count == $past(count) - CNT_W'(1));
  // R5: an empty count stays empty without a write
  p_count_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !w_count) |=> count == '0);
  // R3: no word is taken before the table exists
  p_no_take_unbuilt_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(tbl_ready));
  // R6: job completion raises the expiry flag
  p_fin_sets_exp_r6: assert property (@(posedge clk) disable iff (rst)
    eng_fin |=> st_exp);
  // R7: the expiry flag holds unless cleared by a one
  p_exp_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (st_exp && !(w_status && bus_wdata[ST_EXPIRED])) |=> st_exp);
  // R8: the line follows only enabled flags
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(flags & ie)));
  // R9: mismatch only arises in compare mode
  p_mis_cmp_only_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(st_mis) |-> $past(mode) == MODE_CMP);
  // R10: a zero control write halts the run
  p_ctrl_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (w_ctrl && bus_wdata[2:0] == 3'b000) |=> (!run_en && mode == MODE_OFF && !in_ready));
endmodule

// File: tb/crc_accel_test.sv
module crc_accel_test;
  localparam int CLK_NS = 10;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  crc_accel uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic br(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] p,
                                           input logic [31:0] w);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[31] ^ w[i];
      r = r << 1;
      if (fb) r = r ^ p;
    end
    return r;
  endfunction

  task automatic feed(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // driver: loads a job and pushes its expected result to the scoreboard
  task automatic drive_job(input logic [31:0] seed, input logic [31:0] poly,
                           input int n, input logic [31:0] base, input bit mid_peek);
    logic [31:0] e = seed;
    logic [31:0] v;
    for (int i = 0; i < n; i++) e = ref_step(e, poly, base ^ (32'h9E3779B9 * i));
    exp_q.push_back(e);
    bw(5, seed);
    bw(7, n);
    for (int i = 0; i < n; i++) begin
      feed(base ^ (32'h9E3779B9 * i));
      if (mid_peek && i == 0) begin
        br(7, v);
        chk("R5 count after first word", v, n - 1);
      end
    end
  endtask

  // monitor: waits for completion, pops the scoreboard and compares
  task automatic monitor(input string tag, input bit by_irq);
    logic [31:0] v;
    logic [31:0] e;
    int n = 0;
    if (by_irq) begin
      while (!irq && n < 300) begin @(negedge clk); n++; end
      chk({tag, " R6 irq on expiry"}, 32'(irq), 32'd1);
    end else begin
      repeat (40) @(negedge clk);
    end
    br(1, v);
    chk({tag, " R6 expired bit"}, 32'(v[0]), 32'd1);
    br(6, v);
    e = exp_q.pop_front();
    chk({tag, " R4 crc result"}, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e;
    int n;
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    in_valid = 0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 in_ready", 32'(in_ready), 0);
    br(0, v); chk("R1 ctrl", v, 0);
    br(1, v); chk("R1 status", v, 0);
    br(6, v); chk("R1 result", v, 0);

    // R3 no acceptance without a table
    bw(0, 32'h3);
    bw(7, 3);
    @(negedge clk); in_valid = 1'b1; in_data = 32'hDEADBEEF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R3 in_ready before table", 32'(in_ready), 0);
    end
    in_valid = 1'b0;
    br(7, v); chk("R3 count untouched", v, 3);

    // R2 restarted build and its latency
    bw(4, 32'h1EDC6F41);
    repeat (100) @(posedge clk);
    br(1, v); chk("R2 mid-build ready", 32'(v[2]), 0);
    bw(4, 32'h04C11DB7);
    repeat (255) @(posedge clk);
    br(1, v); chk("R2 ready at edge 256 pre", 32'(v[2]), 0);
    br(1, v); chk("R2 ready after 256", 32'(v[2]), 1);

    // R11 seed readback, R12 reload register
    bw(5, 32'hA5A55A5A);
    br(5, v); chk("R11 seed readback", v, 32'hA5A55A5A);
    bw(8, 0);
    br(8, v); chk("R12 reload zero", v, 0);
    bw(8, 32'h00C0FFEE);
    br(8, v); chk("R12 reload value", v, 32'h00C0FFEE);

    // R4 R5 R6 first job with expiry interrupt
    bw(2, 32'h1);
    br(2, v); chk("R8 enable readback", v, 1);
    drive_job(32'hFFFFFFFF, 32'h04C11DB7, 3, 32'h12345678, 1'b1);
    monitor("job1", 1'b1);
    br(7, v); chk("R5 count at zero", v, 0);
    chk("R3 in_ready with empty count", 32'(in_ready), 0);

    // R7 write-zero keeps, write-one clears
    bw(1, 32'h0);
    br(1, v); chk("R7 write zero keeps", 32'(v[0]), 1);
    bw(1, 32'h1);
    repeat (2) @(negedge clk);
    chk("R7 irq after clear", 32'(irq), 0);
    br(1, v); chk("R7 write one clears", 32'(v[0]), 0);

    // R8 gating: flag pending with enable off, then enable it
    bw(3, 32'h1);
    drive_job(32'h00000000, 32'h04C11DB7, 2, 32'hCAFEF00D, 1'b0);
    monitor("job2", 1'b0);
    chk("R8 irq masked", 32'(irq), 0);
    bw(2, 32'h1);
    repeat (2) @(negedge clk);
    chk("R8 irq after enable", 32'(irq), 1);
    bw(1, 32'h1);

    // R2 R4 second polynomial
    bw(4, 32'h1EDC6F41);
    n = 0;
    do begin br(1, v); n++; end while (!v[2] && n < 400);
    drive_job(32'h12345678, 32'h1EDC6F41, 5, 32'h0BADC0DE, 1'b0);
    monitor("job3", 1'b1);
    br(1, v); chk("R9 no mismatch in calc mode", 32'(v[1]), 0);
    bw(1, 32'h1);

    // R9 compare mode: matching then differing
    e = 32'h5555AAAA;
    for (int i = 0; i < 2; i++) e = ref_step(e, 32'h1EDC6F41, 32'h31415926 ^ (32'h9E3779B9 * i));
    bw(9, e);
    bw(0, 32'h5);
    drive_job(32'h5555AAAA, 32'h1EDC6F41, 2, 32'h31415926, 1'b0);
    monitor("job4", 1'b1);
    br(1, v); chk("R9 match leaves mismatch clear", 32'(v[1]), 0);
    bw(1, 32'h1);
    bw(9, e ^ 32'h1);
    bw(2, 32'h2);
    drive_job(32'h5555AAAA, 32'h1EDC6F41, 2, 32'h31415926, 1'b0);
    monitor("job5", 1'b1);
    br(1, v); chk("R9 mismatch flagged", 32'(v[1]), 1);
    bw(1, 32'h3);
    repeat (2) @(negedge clk);
    chk("R7 irq after clearing both", 32'(irq), 0);

    // R10 zero control write
    bw(0, 32'h0);
    br(0, v); chk("R10 ctrl cleared", v, 0);
    bw(7, 2);
    @(negedge clk); in_valid = 1'b1; in_data = 32'h1;
    repeat (3) @(negedge clk);
    chk("R10 in_ready off", 32'(in_ready), 0);
    in_valid = 1'b0;
    br(7, v); chk("R10 count untouched", v, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule